// File: doc/BRIEF.md
# Accumulator Bit-Field Extractor

This block pulls a 32-bit result out of a 64-bit accumulator value presented at its input. It works in one of two ways. In field mode it returns a variable-width field whose top bit sits at a position held in a small control register. It can then step that position down past the field just taken, so that a sequence of operations walks through the accumulator from high bits to low bits. In shift mode it applies an arithmetic right shift to the accumulator, with optional round-half-up before the shift and optional saturation of the result to the signed 32-bit range.

The control register has three fields: a 6-bit position, a field-failure flag and a sticky overflow flag. Field operations update the position and the failure flag. Shift operations can set the overflow flag. The register can be loaded as a whole through a write strobe. One operation is accepted per clock when `op_valid` is high. Its result is registered and appears one cycle later together with `res_valid`. Any control-register update from the same operation is made on that same edge.

Top module: `acc_field_extract`

## Requirements
- R1: After reset `res_valid`, `res_out`, `ctl_pos`, `ctl_fail` and `ctl_ovf` are all zero. `res_valid` is high exactly in the cycle after an accepted operation. `res_out` keeps its value while no operation is accepted.
- R2: In field mode (`op_kind` 2'b00 or 2'b01) the size is `amt_in[4:0]` and bits 7:5 have no effect. When `ctl_pos` >= size, the result is accumulator bits [ctl_pos : ctl_pos-size], zero-extended, and `ctl_fail` is cleared.
- R3: In field mode, when `ctl_pos` < size, the result is zero, `ctl_fail` is set and `ctl_pos` is unchanged.
- R4: In decrementing field mode (`op_kind` 2'b01) a successful extraction loads `ctl_pos` with ctl_pos-size-1. When ctl_pos equals size it loads 63.
- R5: `op_kind` 2'b00 and shift mode never change `ctl_pos`. Shift mode leaves `ctl_fail` unchanged.
- R6: In shift mode (`op_kind[1]` = 1) the shift amount is `amt_in[4:0]`. The result is the low 32 bits of the accumulator shifted arithmetically right. A shift of zero returns the accumulator's low 32 bits. With `rnd_en` and a non-zero shift, 2^(shift-1) is added before shifting.
- R7: In shift mode with rounding, a positive accumulator that turns negative when the rounding term is added counts as an overflow. With `sat_en` the pre-shift value is replaced by 2^63-1. Without it the wrapped sum is shifted.
- R8: In shift mode, an accumulator outside [-2^31, 2^31-1] counts as an overflow. Any overflow sets `ctl_ovf`. With `sat_en` and an overflow, the shifted value is clamped to [-2^31, 2^31-1]. Otherwise its low 32 bits are returned.
- R9: `ctl_ovf` is sticky. Only a control write clears it, and field operations never change it.
- R10: `ctl_wr` loads `ctl_pos`, `ctl_fail` and `ctl_ovf` from the write inputs and wins over any update from an operation in the same cycle. That operation's result still uses the position held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_kind | input | 2 | 00 field, 01 field with position step-down, 1x shift |
| acc_in | input | 64 | Accumulator value |
| amt_in | input | 8 | Field size or shift amount (low 5 bits used) |
| rnd_en | input | 1 | Shift mode: round before shifting |
| sat_en | input | 1 | Shift mode: saturate on overflow |
| ctl_wr | input | 1 | Load the control register |
| ctl_pos_wr | input | 6 | Position value to load |
| ctl_fail_wr | input | 1 | Failure flag value to load |
| ctl_ovf_wr | input | 1 | Overflow flag value to load |
| res_valid | output | 1 | Result valid, one cycle after `op_valid` |
| res_out | output | 32 | Registered result |
| ctl_pos | output | 6 | Current extraction position |
| ctl_fail | output | 1 | Last field operation did not fit |
| ctl_ovf | output | 1 | Sticky shift overflow flag |

## Verification
Field mode is driven with random positions and sizes. Every so often the position exactly equals the size, lies just below it, or sits at 63 with the widest field. This separates an off-by-one in the fit test from an error in the step-down wrap. Shift mode is fed accumulators drawn from five classes: full 64-bit random values, sign-extended 32-bit values, values just either side of the signed 32-bit limits, values close to 2^63-1, and small values. These separate the saturation clamp from the rounding overflow and from the out-of-range test on the unshifted accumulator. Directed cases cover a zero shift, rounding overflow with and without saturation, an out-of-range accumulator whose shifted value fits, and a control write in the same cycle as an operation.

// File: rtl/afx_pkg.sv
package afx_pkg;
  parameter int ACC_W = 64;
  parameter int RES_W = 32;
  parameter int AMT_W = 8;

  localparam logic [1:0] KIND_FIELD     = 2'b00;
  localparam logic [1:0] KIND_FIELD_DEC = 2'b01;
  localparam logic [1:0] KIND_SHIFT     = 2'b10;
endpackage

// File: rtl/afx_field_unit.sv
module afx_field_unit #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int POS_W = $clog2(ACC_W),
  parameter int SZ_W  = $clog2(RES_W)
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [POS_W-1:0] pos,
  input  logic [SZ_W-1:0]  size,
  output logic [RES_W-1:0] field,
  output logic             fits,
  output logic [POS_W-1:0] next_pos
);
  logic [POS_W:0]   size_x;
  logic [POS_W-1:0] lo_bit;
  logic [RES_W-1:0] sh_fld;

  // Fit test: the low end of the field must not fall below bit 0.
  function automatic logic field_fits(input logic [POS_W-1:0] p, input logic [POS_W:0] s);
    return {1'b0, p} >= s;
  endfunction

  assign size_x   = {{(POS_W+1-SZ_W){1'b0}}, size};
  assign fits     = field_fits(pos, size_x);
  assign lo_bit   = pos - size_x[POS_W-1:0];
  // Position after the field; wraps to all ones when the field ended at bit 0.
  assign next_pos = lo_bit - POS_W'(1);
  assign sh_fld   = RES_W'(acc >> lo_bit);

  for (genvar i = 0; i < RES_W; i++) begin : g_mask
    localparam logic [SZ_W:0] IDX = (SZ_W+1)'(i);
    assign field[i] = fits && ({1'b0, size} >= IDX) && sh_fld[i];
  end
endmodule

// File: rtl/afx_shift_unit.sv
module afx_shift_unit #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int SA_W  = $clog2(RES_W)
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [SA_W-1:0]  sa,
  input  logic             rnd,
  input  logic             sat,
  output logic [RES_W-1:0] result,
  output logic             rnd_ovf,
  output logic             acc_ovf,
  output logic             any_ovf
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

  logic [ACC_W-1:0] half, sum, pre, shifted;
  logic             sh_fits;

  // True when the top bits down to the result sign bit are all equal.
  function automatic logic fits_narrow(input logic [ACC_W-1:0] v);
    return (&v[ACC_W-1:RES_W-1]) || !(|v[ACC_W-1:RES_W-1]);
  endfunction

  function automatic logic [RES_W-1:0] clamp_narrow(input logic [ACC_W-1:0] v);
    if (fits_narrow(v)) return v[RES_W-1:0];
    return v[ACC_W-1] ? RES_MIN : RES_MAX;
  endfunction

  assign half    = (ACC_W'(1) << sa) >> 1;
  assign sum     = acc + half;
  assign rnd_ovf = rnd && (sa != '0) && !acc[ACC_W-1] && sum[ACC_W-1];
  assign pre     = (rnd_ovf && sat) ? ACC_MAX : (rnd ? sum : acc);
  assign shifted = $unsigned($signed(pre) >>> sa);
  assign acc_ovf = !fits_narrow(acc);
  assign any_ovf = rnd_ovf || acc_ovf;
  assign sh_fits = fits_narrow(shifted);
  assign result  = (any_ovf && sat && !sh_fits) ? clamp_narrow(shifted) : shifted[RES_W-1:0];
endmodule

// File: rtl/afx_ctl_reg.sv
module afx_ctl_reg #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [POS_W-1:0] wr_pos,
  input  logic             wr_fail,
  input  logic             wr_ovf,
  input  logic             upd_pos,
  input  logic [POS_W-1:0] new_pos,
  input  logic             upd_fail,
  input  logic             new_fail,
  input  logic             set_ovf,
  output logic [POS_W-1:0] pos,
  output logic             fail,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos  <= '0;
      fail <= 1'b0;
      ovf  <= 1'b0;
    end else if (wr) begin
      pos  <= wr_pos;
      fail <= wr_fail;
      ovf  <= wr_ovf;
    end else begin
      if (upd_pos)  pos  <= new_pos;
      if (upd_fail) fail <= new_fail;
      if (set_ovf)  ovf  <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_field_extract.sv
module acc_field_extract
  import afx_pkg::*;
#(
  parameter int ACC_W_P = afx_pkg::ACC_W,
  parameter int RES_W_P = afx_pkg::RES_W,
  parameter int AMT_W_P = afx_pkg::AMT_W,
  localparam int POS_W  = $clog2(ACC_W_P),
  localparam int SZ_W   = $clog2(RES_W_P)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_kind,
  input  logic [ACC_W_P-1:0] acc_in,
  input  logic [AMT_W_P-1:0] amt_in,
  input  logic               rnd_en,
  input  logic               sat_en,
  input  logic               ctl_wr,
  input  logic [POS_W-1:0]   ctl_pos_wr,
  input  logic               ctl_fail_wr,
  input  logic               ctl_ovf_wr,
  output logic               res_valid,
  output logic [RES_W_P-1:0] res_out,
  output logic [POS_W-1:0]   ctl_pos,
  output logic               ctl_fail,
  output logic               ctl_ovf
);
  logic [SZ_W-1:0]    amt_lo;
  logic               unused_amt_hi;
  logic               is_field, is_dec, is_shift;
  logic [RES_W_P-1:0] fld_res, shf_res;
  logic               fld_fits;
  logic [POS_W-1:0]   fld_next_pos;
  logic               shf_rnd_ovf, shf_acc_ovf, shf_ovf;

  assign amt_lo        = amt_in[SZ_W-1:0];
  assign unused_amt_hi = ^amt_in[AMT_W_P-1:SZ_W];
  assign is_shift      = op_valid && op_kind[1];
  assign is_field      = op_valid && !op_kind[1];
  assign is_dec        = is_field && (op_kind == KIND_FIELD_DEC);

  afx_field_unit #(.ACC_W(ACC_W_P), .RES_W(RES_W_P), .POS_W(POS_W), .SZ_W(SZ_W)) u_field (
    .acc(acc_in), .pos(ctl_pos), .size(amt_lo),
    .field(fld_res), .fits(fld_fits), .next_pos(fld_next_pos)
  );

  afx_shift_unit #(.ACC_W(ACC_W_P), .RES_W(RES_W_P), .SA_W(SZ_W)) u_shift (
    .acc(acc_in), .sa(amt_lo), .rnd(rnd_en), .sat(sat_en),
    .result(shf_res), .rnd_ovf(shf_rnd_ovf), .acc_ovf(shf_acc_ovf), .any_ovf(shf_ovf)
  );

  afx_ctl_reg #(.POS_W(POS_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr(ctl_wr), .wr_pos(ctl_pos_wr), .wr_fail(ctl_fail_wr), .wr_ovf(ctl_ovf_wr),
    .upd_pos(is_dec && fld_fits), .new_pos(fld_next_pos),
    .upd_fail(is_field), .new_fail(!fld_fits),
    .set_ovf(is_shift && shf_ovf),
    .pos(ctl_pos), .fail(ctl_fail), .ovf(ctl_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_out   <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_out <= op_kind[1] ? shf_res : fld_res;
    end
  end
endmodule

// File: rtl/acc_field_extract_chk.sv
module acc_field_extract_chk #(
  parameter int RES_W = 32,
  parameter int POS_W = 6,
  parameter int SZ_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic [RES_W-1:0] acc_lo,
  input logic [SZ_W-1:0]  amt_lo,
  input logic             sat_en,
  input logic             ctl_wr,
  input logic [POS_W-1:0] ctl_pos_wr,
  input logic             ctl_fail_wr,
  input logic             ctl_ovf_wr,
  input logic             res_valid,
  input logic [RES_W-1:0] res_out,
  input logic [POS_W-1:0] ctl_pos,
  input logic             ctl_fail,
  input logic             ctl_ovf,
  input logic             shf_ovf
);
  logic [POS_W-1:0] size_x;
  assign size_x = {{(POS_W-SZ_W){1'b0}}, amt_lo};

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_out)));
  a_r3_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_kind[1] && !ctl_wr && (ctl_pos < size_x)) |=> (ctl_fail && res_out == '0));
  a_r4_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'b01 && !ctl_wr && ctl_pos == size_x) |=> (ctl_pos == '1));
  a_r5_pos_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind != 2'b01 && !ctl_wr) |=> $stable(ctl_pos));
  a_r6_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind[1] && amt_lo == '0 && !sat_en) |=> (res_out == $past(acc_lo)));
  a_r8_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind[1] && !ctl_wr && shf_ovf) |=> ctl_ovf);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ovf && !ctl_wr) |=> ctl_ovf);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_pos == $past(ctl_pos_wr) && ctl_fail == $past(ctl_fail_wr)
                && ctl_ovf == $past(ctl_ovf_wr)));
endmodule

bind acc_field_extract acc_field_extract_chk #(.RES_W(RES_W_P), .POS_W(POS_W), .SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .acc_lo(acc_in[RES_W_P-1:0]), .amt_lo(amt_lo), .sat_en(sat_en),
  .ctl_wr(ctl_wr), .ctl_pos_wr(ctl_pos_wr), .ctl_fail_wr(ctl_fail_wr), .ctl_ovf_wr(ctl_ovf_wr),
  .res_valid(res_valid), .res_out(res_out), .ctl_pos(ctl_pos), .ctl_fail(ctl_fail),
  .ctl_ovf(ctl_ovf), .shf_ovf(shf_ovf)
);

// File: tb/acc_field_extract_tb.sv
module acc_field_extract_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic [63:0] acc_in = '0;
  logic [7:0]  amt_in = '0;
  logic        rnd_en = 1'b0, sat_en = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [5:0]  ctl_pos_wr = '0;
  logic        ctl_fail_wr = 1'b0, ctl_ovf_wr = 1'b0;
  logic        res_valid;
  logic [31:0] res_out;
  logic [5:0]  ctl_pos;
  logic        ctl_fail, ctl_ovf;

  int tests = 0;
  int fails = 0;
  logic [5:0] m_pos = '0;
  logic m_fail = 1'b0, m_ovf = 1'b0;
  logic [31:0] m_res = '0;

  always #4 clk = ~clk;

  acc_field_extract u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .acc_in(acc_in),
    .amt_in(amt_in), .rnd_en(rnd_en), .sat_en(sat_en), .ctl_wr(ctl_wr),
    .ctl_pos_wr(ctl_pos_wr), .ctl_fail_wr(ctl_fail_wr), .ctl_ovf_wr(ctl_ovf_wr),
    .res_valid(res_valid), .res_out(res_out), .ctl_pos(ctl_pos), .ctl_fail(ctl_fail),
    .ctl_ovf(ctl_ovf)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Field model: position step arithmetic done in plain integers.
  task automatic m_field(input logic [63:0] a, input int sz, input logic dec);
    int p = int'(m_pos);
    if (p >= sz) begin
      m_res  = 32'((a >> (p - sz)) & ((64'd1 << (sz + 1)) - 64'd1));
      m_fail = 1'b0;
      if (dec) m_pos = (p - sz - 1 < 0) ? 6'd63 : 6'(p - sz - 1);
    end else begin
      m_res  = '0;
      m_fail = 1'b1;
    end
  endtask

  // Shift model: 66-bit signed arithmetic so rounding overflow is visible.
  task automatic m_shift(input logic [63:0] a, input int s, input logic rnd, input logic sat);
    logic signed [65:0] w;
    logic signed [63:0] pre, sh;
    logic rov, ov;
    w = $signed({{2{a[63]}}, a});
    if (rnd && s > 0) w = w + (66'sd1 <<< (s - 1));
    rov = w > 66'sd9223372036854775807;
    pre = (rov && sat) ? 64'sh7FFF_FFFF_FFFF_FFFF : w[63:0];
    sh  = pre >>> s;
    ov  = rov || ($signed(a) > 64'sd2147483647) || ($signed(a) < -64'sd2147483648);
    if (ov) m_ovf = 1'b1;
    if (ov && sat && sh > 64'sd2147483647)       m_res = 32'h7FFF_FFFF;
    else if (ov && sat && sh < -64'sd2147483648) m_res = 32'h8000_0000;
    else                                         m_res = sh[31:0];
  endtask

  task automatic run_op(input logic [1:0] kind, input logic [63:0] a, input logic [7:0] amt,
                        input logic rnd, input logic sat, input string req);
    if (kind[1]) m_shift(a, int'(amt[4:0]), rnd, sat);
    else         m_field(a, int'(amt[4:0]), kind[0]);
    @(negedge clk);
    op_valid = 1'b1; op_kind = kind; acc_in = a; amt_in = amt; rnd_en = rnd; sat_en = sat;
    @(negedge clk);
    op_valid = 1'b0;
    check({req, " valid"}, 64'(res_valid), 64'd1);
    check({req, " result"}, 64'(res_out), 64'(m_res));
    check({req, " pos"}, 64'(ctl_pos), 64'(m_pos));
    check({req, " fail"}, 64'(ctl_fail), 64'(m_fail));
    check({req, " ovf"}, 64'(ctl_ovf), 64'(m_ovf));
  endtask

  task automatic ctl_write(input logic [5:0] p, input logic f, input logic o);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_pos_wr = p; ctl_fail_wr = f; ctl_ovf_wr = o;
    @(negedge clk);
    ctl_wr = 1'b0;
    m_pos = p; m_fail = f; m_ovf = o;
  endtask

  function automatic logic [63:0] pick_acc(input int cls);
    logic [63:0] r = {$urandom(), $urandom()};
    case (cls)
      0: return r;
      1: return {{32{r[31]}}, r[31:0]};
      2: return r[0] ? 64'h0000_0000_7FFF_FFF0 + 64'(r[5:1])
                     : 64'hFFFF_FFFF_8000_000F - 64'(r[5:1]);
      3: return 64'h7FFF_FFFF_FFFF_FFFF - 64'(r[7:0]);
      default: return {{56{r[63]}}, r[7:0]};
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1F));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", 64'(res_valid), 0);
    check("R1 reset result", 64'(res_out), 0);
    check("R1 reset pos", 64'(ctl_pos), 0);
    check("R1 reset flags", {62'd0, ctl_fail, ctl_ovf}, 0);

    // R2: widest field at the top position
    ctl_write(6'd63, 1'b0, 1'b0);
    run_op(2'b00, 64'hDEAD_BEEF_0123_4567, 8'd31, 1'b0, 1'b0, "R2 top field");
    // R2: upper size bits ignored (8'hE3 acts as size 3)
    ctl_write(6'd7, 1'b1, 1'b0);
    run_op(2'b00, 64'h0000_0000_0000_00A5, 8'hE3, 1'b0, 1'b0, "R2 amt high bits");
    // R3: position below size
    run_op(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 8'd8, 1'b0, 1'b0, "R3 no fit");
    // R4: step-down then wrap when position equals size
    ctl_write(6'd20, 1'b0, 1'b0);
    run_op(2'b01, 64'h0000_0000_00F0_F0F0, 8'd9, 1'b0, 1'b0, "R4 step");
    run_op(2'b01, 64'h0000_0000_00F0_F0F0, 8'd10, 1'b0, 1'b0, "R4 wrap");
    run_op(2'b01, 64'h0000_0000_00F0_F0F0, 8'd31, 1'b0, 1'b0, "R4 from top");
    // R6: zero shift returns low bits
    run_op(2'b10, 64'h0000_0000_1234_5678, 8'd0, 1'b1, 1'b0, "R6 zero shift");
    run_op(2'b11, 64'hFFFF_FFFF_F000_0001, 8'd4, 1'b1, 1'b1, "R6 round");
    // R7: rounding overflow with and without saturation
    ctl_write(6'd0, 1'b0, 1'b0);
    run_op(2'b10, 64'h7FFF_FFFF_FFFF_FFFF, 8'd1, 1'b1, 1'b1, "R7 sat");
    ctl_write(6'd0, 1'b0, 1'b0);
    run_op(2'b10, 64'h7FFF_FFFF_FFFF_FFFF, 8'd1, 1'b1, 1'b0, "R7 wrap");
    // R8: out-of-range accumulator whose shifted value fits
    ctl_write(6'd0, 1'b0, 1'b0);
    run_op(2'b10, 64'h0000_0001_0000_0000, 8'd4, 1'b0, 1'b1, "R8 fits after shift");
    // R9: flag stays through an in-range shift and a field op
    run_op(2'b10, 64'h0000_0000_0000_0040, 8'd2, 1'b0, 1'b0, "R9 sticky shift");
    run_op(2'b00, 64'h0000_0000_0000_0040, 8'd0, 1'b0, 1'b0, "R9 sticky field");
    // R1: idle cycles hold the result
    repeat (2) @(negedge clk);
    check("R1 idle valid", 64'(res_valid), 0);
    check("R1 idle hold", 64'(res_out), 64'(m_res));
    // R10: control write in the same cycle as a decrementing op
    ctl_write(6'd40, 1'b0, 1'b0);
    m_field(64'hFEDC_BA98_7654_3210, 8, 1'b1);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'b01; acc_in = 64'hFEDC_BA98_7654_3210; amt_in = 8'd8;
    ctl_wr = 1'b1; ctl_pos_wr = 6'd5; ctl_fail_wr = 1'b1; ctl_ovf_wr = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; ctl_wr = 1'b0;
    m_pos = 6'd5; m_fail = 1'b1; m_ovf = 1'b1;
    check("R10 result old pos", 64'(res_out), 64'(m_res));
    check("R10 pos", 64'(ctl_pos), 64'd5);
    check("R10 flags", {62'd0, ctl_fail, ctl_ovf}, 64'd3);

    // Random mix
    for (int n = 0; n < 800; n++) begin
      logic [1:0] k;
      logic [63:0] a;
      if ($urandom() % 8 == 0) ctl_write(6'($urandom()), 1'($urandom()), 1'b0);
      k = 2'($urandom());
      a = pick_acc(int'($urandom() % 5));
      if (k[1]) run_op(k, a, 8'($urandom()), 1'($urandom()), 1'($urandom()), "R6/R8 random shift");
      else      run_op(k, a, 8'($urandom()), 1'($urandom()), 1'($urandom()), "R2/R4 random field");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule